// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block keeps the two trace bits of a processor status word and decides when a single-step trace trap is requested. The trace-enable bit (T) is set by software to single-step a program. At each instruction start T is copied into a separate trace-pending bit (P). The trap fires only if P is still set when the instruction ends. P is kept apart from T for three reasons. It makes sure only one trace trap is raised per instruction. It lets any other trap or interrupt finish its full service before the trace is taken. It lets an undefined-instruction trap entry skip the T-to-P copy.

Exception entry, exception return, status-word loads and instruction boundaries all reach the block as one-cycle strobes from the core's sequencer. On each exception entry the block produces the status-word copy to be pushed, with the required bits cleared before the save. It then clears the required bits in the live word. The trace request is a level that stays up until it is acknowledged. While any other exception request is pending, the request is masked, because the trace trap has the lowest priority.

Top module: `trace_step_ctl`

## Requirements
- R1: After reset the live word, the saved copy and `trc_req` are all zero.
- R2: An `insn_begin` strobe copies T (bit 1) into P (bit 10). The new value appears one clock later.
- R3: An `insn_end` strobe while P is set latches a trace request, which shows on `trc_req` one clock later. An `insn_end` with P clear latches nothing.
- R4: The trace trap has the lowest priority. While `exc_pend` is high, `trc_req` is low in the same cycle, and the latched request is kept.
- R5: `trc_ack` while `trc_req` is high does three things at the next clock. It drops the request. It saves the live word with P cleared. It clears T, U (bit 8), S (bit 9) and P in the live word.
- R6: An `exc_entry` strobe clears T, U, S and P in the live word and drops any latched trace request. For an interrupt (`exc_kind`=0) it also clears I (bit 11). A trap is `exc_kind`=1 or 3, and an undefined-instruction trap is `exc_kind`=2. The word before the entry is saved unchanged, except as stated in R7.
- R7: For an interrupt entry, P is cleared in the saved copy. The exception to this is when a trace request is latched or `wait_state` is high: then P is kept, so the deferred trace follows the return.
- R8: An undefined-instruction entry does not count as an instruction start. An `insn_begin` in the same cycle is ignored, so the saved P is the old P and not T.
- R9: An `exc_return` strobe loads the live word from `ret_psr`. If the restored P is set, a trace request is latched one clock later.
- R10: `psr_wr` loads the live word from `psr_wdata`. If this clears T and P before `insn_end`, no trace request is raised for that instruction.
- R11: With P set during a wait state, an interrupt keeps P in the saved copy. The trace request is then raised after that interrupt's return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_begin | input | 1 | Instruction start strobe |
| insn_end | input | 1 | Instruction end strobe |
| psr_wr | input | 1 | Status-word load strobe |
| psr_wdata | input | 12 | Value for a status-word load |
| exc_entry | input | 1 | Exception entry strobe |
| exc_kind | input | 2 | Entry kind: 0 interrupt, 1/3 trap, 2 undefined instruction |
| exc_return | input | 1 | Return-from-trap or return-from-interrupt strobe |
| ret_psr | input | 12 | Status word restored by the return |
| wait_state | input | 1 | Core is waiting for an interrupt |
| exc_pend | input | 1 | Another exception request is pending |
| trc_ack | input | 1 | Trace trap taken |
| t_bit | output | 1 | Live trace-enable bit |
| p_bit | output | 1 | Live trace-pending bit |
| psr_live | output | 12 | Live status word |
| psr_saved | output | 12 | Status-word copy for the stack |
| trc_req | output | 1 | Trace trap request (level) |

## Verification
Every strobe acts at the next rising edge. The bench therefore applies a stimulus just after an edge and samples the live word, the saved copy and `trc_req` one nanosecond after the following edge. The only same-cycle path is the masking of `trc_req` by `exc_pend`. That path is checked by changing `exc_pend` between edges and sampling after a short settle. Deferred traces are followed across a full entry, handler and return sequence. In that sequence the request must be absent during the handler and present exactly one clock after the return.

// File: rtl/trc_pkg.sv
// Shared constants and types for the trace trap controller.
// Assumes a 12-bit status word; bit positions are fixed here and used by all modules.
package trc_pkg;
    localparam int PSR_W  = 12;
    localparam int KIND_W = 2;
    localparam int T_POS  = 1;
    localparam int U_POS  = 8;
    localparam int S_POS  = 9;
    localparam int P_POS  = 10;
    localparam int I_POS  = 11;

    typedef logic [PSR_W-1:0] psr_t;

    typedef enum logic [KIND_W-1:0] {
        EXC_INTR  = 2'd0,
        EXC_TRAP  = 2'd1,
        EXC_UNDEF = 2'd2,
        EXC_TRAP2 = 2'd3
    } exc_kind_t;

    // One-hot mask for a single status bit.
    function automatic psr_t bit_of(input int pos);
        psr_t m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    // Bits cleared in the live word after the save, per entry kind.
    function automatic psr_t live_clear(input exc_kind_t k);
        psr_t m;
        m = bit_of(T_POS) | bit_of(U_POS) | bit_of(S_POS) | bit_of(P_POS);
        if (k == EXC_INTR)
            m = m | bit_of(I_POS);
        return m;
    endfunction
endpackage

// File: rtl/trc_psr_reg.sv
// Live status word register.
// Does: applies trace entry, exception entry, return, loads and the T-to-P copy.
// Assumes: at most one of these events matters per cycle; earlier ones in the
// priority chain win, so an insn_begin beside an entry is ignored.
module trc_psr_reg
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trc_take,
    input  logic      exc_entry,
    input  exc_kind_t kind,
    input  logic      exc_return,
    input  psr_t      ret_psr,
    input  logic      psr_wr,
    input  psr_t      psr_wdata,
    input  logic      insn_begin,
    output psr_t      psr
);
    localparam psr_t TRC_CLR = live_clear(EXC_TRAP);

    // Update the live word by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psr <= '0;
        else if (trc_take)
            psr <= psr & ~TRC_CLR;
        else if (exc_entry)
            psr <= psr & ~live_clear(kind);
        else if (exc_return)
            psr <= ret_psr;
        else if (psr_wr)
            psr <= psr_wdata;
        else if (insn_begin)
            psr[P_POS] <= psr[T_POS];
    end
endmodule

// File: rtl/trc_save_sel.sv
// Saved status-word copy.
// Does: captures the word to be stacked on trace entry or exception entry,
// clearing P beforehand where the entry kind requires it.
// Assumes: the copy is consumed by the stack logic before the next entry.
module trc_save_sel
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trc_take,
    input  logic      exc_entry,
    input  exc_kind_t kind,
    input  logic      wait_state,
    input  logic      trc_lat,
    input  psr_t      psr,
    output psr_t      saved
);
    localparam psr_t P_MASK = bit_of(P_POS);

    logic keep_p;

    // An interrupt drops P from the copy unless a trace is owed.
    always_comb begin
        keep_p = (kind != EXC_INTR) || trc_lat || wait_state;
    end

    // Capture the copy on any entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            saved <= '0;
        else if (trc_take)
            saved <= psr & ~P_MASK;
        else if (exc_entry)
            saved <= keep_p ? psr : (psr & ~P_MASK);
    end
endmodule

// File: rtl/trc_req_gen.sv
// Trace request latch and priority mask.
// Does: latches a request at an instruction end with P set, or at a return
// restoring P; drops it on acknowledge or another entry; masks it while any
// other exception is pending.
// Assumes: trc_ack is only meaningful while the request is visible.
module trc_req_gen
    import trc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic psr_wr,
    input  logic exc_entry,
    input  logic exc_return,
    input  psr_t ret_psr,
    input  psr_t psr,
    input  logic exc_pend,
    input  logic trc_ack,
    output logic trc_lat,
    output logic trc_take,
    output logic trc_req
);
    // Lowest priority: visible only with nothing else pending.
    always_comb begin
        trc_req  = trc_lat && !exc_pend;
        trc_take = trc_ack && trc_req;
    end

    // Hold the owed trace until it is taken or superseded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trc_lat <= 1'b0;
        else if (trc_take || exc_entry)
            trc_lat <= 1'b0;
        else if (exc_return)
            trc_lat <= ret_psr[P_POS];
        else if (insn_end && !psr_wr && psr[P_POS])
            trc_lat <= 1'b1;
    end
endmodule

// File: rtl/trace_step_ctl.sv
// Single-step trace trap controller, top level.
// Does: wires the live word, the saved copy and the request latch together.
// Assumes: all sequencer inputs are one-cycle strobes synchronous to clk.
module trace_step_ctl
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_begin,
    input  logic              insn_end,
    input  logic              psr_wr,
    input  logic [PSR_W-1:0]  psr_wdata,
    input  logic              exc_entry,
    input  logic [KIND_W-1:0] exc_kind,
    input  logic              exc_return,
    input  logic [PSR_W-1:0]  ret_psr,
    input  logic              wait_state,
    input  logic              exc_pend,
    input  logic              trc_ack,
    output logic              t_bit,
    output logic              p_bit,
    output logic [PSR_W-1:0]  psr_live,
    output logic [PSR_W-1:0]  psr_saved,
    output logic              trc_req
);
    exc_kind_t kind;
    psr_t      psr_q;
    psr_t      saved_q;
    logic      trc_lat;
    logic      trc_take;

    // Decode the raw kind field.
    always_comb begin
        kind = exc_kind_t'(exc_kind);
    end

    trc_psr_reg u_psr (
        .clk        (clk),
        .rst_n      (rst_n),
        .trc_take   (trc_take),
        .exc_entry  (exc_entry),
        .kind       (kind),
        .exc_return (exc_return),
        .ret_psr    (ret_psr),
        .psr_wr     (psr_wr),
        .psr_wdata  (psr_wdata),
        .insn_begin (insn_begin),
        .psr        (psr_q)
    );

    trc_save_sel u_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .trc_take   (trc_take),
        .exc_entry  (exc_entry),
        .kind       (kind),
        .wait_state (wait_state),
        .trc_lat    (trc_lat),
        .psr        (psr_q),
        .saved      (saved_q)
    );

    trc_req_gen u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_end   (insn_end),
        .psr_wr     (psr_wr),
        .exc_entry  (exc_entry),
        .exc_return (exc_return),
        .ret_psr    (ret_psr),
        .psr        (psr_q),
        .exc_pend   (exc_pend),
        .trc_ack    (trc_ack),
        .trc_lat    (trc_lat),
        .trc_take   (trc_take),
        .trc_req    (trc_req)
    );

    // Drive the outputs from the registered state.
    always_comb begin
        psr_live  = psr_q;
        psr_saved = saved_q;
        t_bit     = psr_q[T_POS];
        p_bit     = psr_q[P_POS];
    end
endmodule

// File: rtl/trc_chk.sv
// Assertion checker for trace_step_ctl, attached with bind.
// Does: checks the timing rules of the trace bits and the request.
// Assumes: bound to the top so it sees ports plus the request latch.
module trc_chk
    import trc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              insn_begin,
    input logic              insn_end,
    input logic              psr_wr,
    input logic              exc_entry,
    input logic [KIND_W-1:0] exc_kind,
    input logic              exc_return,
    input logic [PSR_W-1:0]  ret_psr,
    input logic              wait_state,
    input logic              exc_pend,
    input logic              trc_ack,
    input logic [PSR_W-1:0]  psr_live,
    input logic [PSR_W-1:0]  psr_saved,
    input logic              trc_req,
    input logic              trc_lat
);
    logic take;
    logic quiet;

    // Events that outrank the instruction strobes.
    always_comb begin
        take  = trc_ack && trc_req;
        quiet = !take && !exc_entry && !exc_return && !psr_wr;
    end

    p_begin_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_begin && quiet) |=> (psr_live[P_POS] == $past(psr_live[T_POS])));

    p_end_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && quiet && psr_live[P_POS]) |=> (trc_req || exc_pend));

    p_pend_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend |-> !trc_req);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!trc_req && !psr_live[P_POS] && !psr_live[T_POS]));

    p_entry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !take) |=> (!trc_req && !psr_live[P_POS] && !psr_live[T_POS]));

    p_intr_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !take && exc_kind == 2'd0 && !wait_state && !trc_lat)
        |=> !psr_saved[P_POS]);

    p_ret_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_entry && !take) |=> (psr_live == $past(ret_psr)));
endmodule

bind trace_step_ctl trc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_begin (insn_begin),
    .insn_end   (insn_end),
    .psr_wr     (psr_wr),
    .exc_entry  (exc_entry),
    .exc_kind   (exc_kind),
    .exc_return (exc_return),
    .ret_psr    (ret_psr),
    .wait_state (wait_state),
    .exc_pend   (exc_pend),
    .trc_ack    (trc_ack),
    .psr_live   (psr_live),
    .psr_saved  (psr_saved),
    .trc_req    (trc_req),
    .trc_lat    (trc_lat)
);

// File: tb/tb_trace_step_ctl.sv
module tb_trace_step_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_begin = 1'b0, insn_end = 1'b0, psr_wr = 1'b0;
    logic [11:0] psr_wdata = '0;
    logic        exc_entry = 1'b0;
    logic [1:0]  exc_kind = '0;
    logic        exc_return = 1'b0;
    logic [11:0] ret_psr = '0;
    logic        wait_state = 1'b0, exc_pend = 1'b0, trc_ack = 1'b0;
    logic        t_bit, p_bit, trc_req;
    logic [11:0] psr_live, psr_saved;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trace_step_ctl dut (
        .clk(clk), .rst_n(rst_n), .insn_begin(insn_begin), .insn_end(insn_end),
        .psr_wr(psr_wr), .psr_wdata(psr_wdata), .exc_entry(exc_entry),
        .exc_kind(exc_kind), .exc_return(exc_return), .ret_psr(ret_psr),
        .wait_state(wait_state), .exc_pend(exc_pend), .trc_ack(trc_ack),
        .t_bit(t_bit), .p_bit(p_bit), .psr_live(psr_live),
        .psr_saved(psr_saved), .trc_req(trc_req)
    );

    // Vector: begin,end,wr,ack, wdata[11:0], expected t,p,req
    localparam int NV = 15;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {4'b0010, 12'h002, 3'b100},
        {4'b1000, 12'h000, 3'b110},
        {4'b0100, 12'h000, 3'b111},
        {4'b0001, 12'h000, 3'b000},
        {4'b0010, 12'h002, 3'b100},
        {4'b1000, 12'h000, 3'b110},
        {4'b0010, 12'h000, 3'b000},
        {4'b0100, 12'h000, 3'b000},
        {4'b1000, 12'h000, 3'b000},
        {4'b0100, 12'h000, 3'b000},
        {4'b0010, 12'h002, 3'b100},
        {4'b1000, 12'h000, 3'b110},
        {4'b0100, 12'h000, 3'b111},
        {4'b1000, 12'h000, 3'b111},
        {4'b0001, 12'h000, 3'b000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: strobes act at the edge, sample 1 ns later, then clear strobes.
    task automatic cyc();
        @(posedge clk);
        #1;
        insn_begin = 0; insn_end = 0; psr_wr = 0; exc_entry = 0;
        exc_return = 0; trc_ack = 0;
    endtask

    task automatic wr(input logic [11:0] v);
        psr_wr = 1; psr_wdata = v; cyc();
    endtask

    task automatic entry(input logic [1:0] k);
        exc_entry = 1; exc_kind = k; cyc();
    endtask

    task automatic ret(input logic [11:0] v);
        exc_return = 1; ret_psr = v; cyc();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 live", psr_live, 12'h000);
        chk("R1 saved", psr_saved, 12'h000);
        chk("R1 req", trc_req, 0);
        rst_n = 1;
        cyc();

        // Table walk: R2 copy, R3 raise/no-raise, R5 ack, R10 suppression
        for (int i = 0; i < NV; i++) begin
            insn_begin = VEC[i][18]; insn_end = VEC[i][17];
            psr_wr = VEC[i][16]; trc_ack = VEC[i][15]; psr_wdata = VEC[i][14:3];
            cyc();
            chk($sformatf("R2/R3/R10 vec%0d t", i), t_bit, VEC[i][2]);
            chk($sformatf("R2/R3/R10 vec%0d p", i), p_bit, VEC[i][1]);
            chk($sformatf("R3/R5 vec%0d req", i), trc_req, VEC[i][0]);
        end

        // R4 masking and R5 saved copy
        wr(12'h302); insn_begin = 1; cyc(); insn_end = 1; cyc();
        chk("R3 req", trc_req, 1);
        exc_pend = 1; #1;
        chk("R4 masked", trc_req, 0);
        cyc();
        chk("R4 held masked", trc_req, 0);
        exc_pend = 0; #1;
        chk("R4 unmasked", trc_req, 1);
        trc_ack = 1; cyc();
        chk("R5 saved", psr_saved, 12'h302);
        chk("R5 live", psr_live, 12'h000);
        chk("R5 req", trc_req, 0);

        // R6/R9 trap inside a traced instruction
        wr(12'hB02); insn_begin = 1; cyc();
        chk("R2 live", psr_live, 12'hF02);
        entry(2'd1);
        chk("R6 trap saved", psr_saved, 12'hF02);
        chk("R6 trap live", psr_live, 12'h800);
        insn_begin = 1; cyc(); insn_end = 1; cyc();
        chk("R6 no trace in handler", trc_req, 0);
        ret(12'hF02);
        chk("R9 live", psr_live, 12'hF02);
        chk("R9 req", trc_req, 1);
        trc_ack = 1; cyc();

        // R6/R7 interrupt with trace pending keeps P in copy
        wr(12'hB02); insn_begin = 1; cyc(); insn_end = 1; cyc();
        entry(2'd0);
        chk("R7 pending saved", psr_saved, 12'hF02);
        chk("R6 intr live", psr_live, 12'h000);
        chk("R6 req dropped", trc_req, 0);
        ret(12'hF02);
        chk("R9 deferred req", trc_req, 1);
        trc_ack = 1; cyc();

        // R7 interrupt before an instruction end: P cleared in copy
        wr(12'hB02); insn_begin = 1; cyc();
        entry(2'd0);
        chk("R7 saved", psr_saved, 12'hB02);
        ret(12'hB02);
        chk("R7 no req", trc_req, 0);
        chk("R9 live", psr_live, 12'hB02);

        // R11 wait state
        wr(12'h002); insn_begin = 1; cyc();
        wait_state = 1;
        cyc();
        chk("R11 no req while waiting", trc_req, 0);
        entry(2'd0);
        wait_state = 0;
        chk("R11 saved", psr_saved, 12'h402);
        chk("R11 none in service", trc_req, 0);
        ret(12'h402);
        chk("R11 req after return", trc_req, 1);
        trc_ack = 1; cyc();

        // R8 undefined entry beside insn_begin: no T-to-P copy
        wr(12'h002);
        insn_begin = 1; exc_entry = 1; exc_kind = 2'd2; cyc();
        chk("R8 saved", psr_saved, 12'h002);
        chk("R8 live", psr_live, 12'h000);

        // R1 reset clears a pending request
        wr(12'h002); insn_begin = 1; cyc(); insn_end = 1; cyc();
        rst_n = 0; cyc();
        chk("R1 reset req", trc_req, 0);
        chk("R1 reset live", psr_live, 12'h000);
        rst_n = 1;

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule